// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block sits between a host byte bus and three counter channels of a programmable interval timer. The host sees four byte locations, selected by a 2-bit address: three per-channel data ports and one command location. It writes a command byte to set up a channel or to freeze that channel's count. The 16-bit values travel through a data port as two bytes in sequence, the low byte first.

For each channel the block keeps the operating mode, the stored 16-bit reload value, a write byte pointer, a read byte pointer and a snapshot register. It gives each channel its mode, a one-cycle pulse when the mode is set, a one-cycle load pulse and the full reload value. It takes each channel's live count as an input. The counting itself is done elsewhere. Read data is registered, so a byte read at a clock edge appears on `rdata` after that edge and stays there until the next read.

Top module: `pit_host_if`

## Requirements
- R1: After reset every channel mode is 0, every reload value is 0, `mode_set` and `load_pulse` are low and `rdata` is 0.
- R2: A command byte at address 3 with bits 7:6 = channel n (0..2) and bits 5:4 = 11 sets channel n's mode to bits 3:1, clears its reload value to 0 and pulses `mode_set[n]` for one cycle. The mode changes only on such a command.
- R3: Two byte writes to data port n (address n) store a reload value, the first byte as bits 7:0 and the second as bits 15:8. `load_pulse[n]` is high for one cycle after the second byte and never after the first. At most one load pulse is high in any cycle.
- R4: A command byte with bits 5:4 = 00 captures the addressed channel's live count in the cycle it is written, and it leaves that channel's mode unchanged.
- R5: After a capture, two reads of the data port return the captured value, bits 7:0 first and then bits 15:8, whatever the live count does in the meantime.
- R6: A capture stays held until both of its bytes have been read. A second capture command for that channel before then has no effect.
- R7: When no capture is held, reads of a data port return the live count, bits 7:0 on the first read and bits 15:8 on the second.
- R8: A mode command for a channel returns that channel's write byte pointer to the low byte, so a pending first byte is discarded.
- R9: A command byte with bits 7:6 = 11 is ignored: no mode, reload value or pulse changes.
- R10: A command byte with bits 5:4 = 01 or 10 is ignored.
- R11: Read data appears on `rdata` in the cycle after `rd_en` and holds until the next data-port read.
- R12: Byte pointers and captures of different channels are independent, so interleaved accesses to two channels each see their own sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Byte location: 0..2 data ports, 3 command |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| live_count | input | 48 | Live counts, channel n in bits 16n+15:16n |
| chan_mode | output | 9 | Modes, channel n in bits 3n+2:3n |
| mode_set | output | 3 | One-cycle pulse per channel when its mode is set |
| load_pulse | output | 3 | One-cycle pulse per channel when a full reload value is written |
| preset | output | 48 | Reload values, channel n in bits 16n+15:16n |

## Verification
The assertions watch the command and write side on every cycle: a mode command clears the reload value and pulses `mode_set`, a mode changes only after a command byte, a reserved channel select changes nothing, and each load pulse follows a data write to its own channel with no two pulses at once. The read side needs the bench's scenarios. Only a known sequence can show that a captured value survives a changing live count, that a second capture is dropped while one is held, and that interleaved reads of two channels keep their byte order.

// File: rtl/pit_if_pkg.sv
package pit_if_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_CAPTURE = 2'b00,
    ACC_LOW     = 2'b01,
    ACC_HIGH    = 2'b10,
    ACC_WORD    = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              spare;
  } cmd_word_t;
endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
  import pit_if_pkg::*;
#(
  parameter int unsigned NCH = 3,
  localparam int unsigned AW = $clog2(NCH + 1)
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    prog_vec,
  output logic [NCH-1:0]    capt_vec,
  output logic [NCH-1:0]    dwr_vec,
  output logic [NCH-1:0]    drd_vec,
  output logic [MODE_W-1:0] mode_val
);
  cmd_word_t cw;
  logic      cmd_hit;
  logic      unused_bits;

  assign cw          = cmd_word_t'(wdata);
  assign cmd_hit     = wr_en && (addr == AW'(NCH));
  assign mode_val    = cw.mode;
  assign unused_bits = cw.spare;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic sel_hit;
    assign sel_hit     = cmd_hit && (cw.sel == 2'(i));
    assign prog_vec[i] = sel_hit && (cw.acc == ACC_WORD);
    assign capt_vec[i] = sel_hit && (cw.acc == ACC_CAPTURE);
    assign dwr_vec[i]  = wr_en && (addr == AW'(i));
    assign drd_vec[i]  = rd_en && (addr == AW'(i));
  end
endmodule

// File: rtl/pit_chan_port.sv
module pit_chan_port
  import pit_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              capt,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              dwr,
  input  logic              drd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  output logic [MODE_W-1:0] mode_q,
  output logic              mset_q,
  output logic              load_q,
  output logic [CNT_W-1:0]  preset_q,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [MODE_W-1:0] mode_d;
  logic              mset_d, load_d;
  logic [CNT_W-1:0]  preset_d, snap_q, snap_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              wptr_q, wptr_d, rptr_q, rptr_d, held_q, held_d;
  logic [CNT_W-1:0]  rd_src;

  always_comb begin
    mode_d   = mode_q;
    preset_d = preset_q;
    snap_d   = snap_q;
    lo_d     = lo_q;
    wptr_d   = wptr_q;
    rptr_d   = rptr_q;
    held_d   = held_q;
    mset_d   = 1'b0;
    load_d   = 1'b0;
    if (prog) begin
      mode_d   = mode_in;
      preset_d = '0;
      wptr_d   = 1'b0;
      rptr_d   = 1'b0;
      held_d   = 1'b0;
      mset_d   = 1'b1;
    end else if (capt) begin
      if (!held_q) begin
        snap_d = live;
        held_d = 1'b1;
        rptr_d = 1'b0;
      end
    end else begin
      if (dwr) begin
        if (!wptr_q) begin
          lo_d   = wdata;
          wptr_d = 1'b1;
        end else begin
          preset_d = {wdata, lo_q};
          load_d   = 1'b1;
          wptr_d   = 1'b0;
        end
      end
      if (drd) begin
        if (rptr_q) begin
          rptr_d = 1'b0;
          held_d = 1'b0;
        end else begin
          rptr_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      preset_q <= '0;
      snap_q   <= '0;
      lo_q     <= '0;
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      held_q   <= 1'b0;
      mset_q   <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      preset_q <= preset_d;
      snap_q   <= snap_d;
      lo_q     <= lo_d;
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      held_q   <= held_d;
      mset_q   <= mset_d;
      load_q   <= load_d;
    end
  end

  assign rd_src  = held_q ? snap_q : live;
  assign rd_byte = rptr_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
  import pit_if_pkg::*;
#(
  parameter int unsigned NCH = 3,
  localparam int unsigned AW = $clog2(NCH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  input  logic [NCH*CNT_W-1:0]    live_count,
  output logic [NCH*MODE_W-1:0]   chan_mode,
  output logic [NCH-1:0]          mode_set,
  output logic [NCH-1:0]          load_pulse,
  output logic [NCH*CNT_W-1:0]    preset
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [NCH-1:0]    prog_vec, capt_vec, dwr_vec, drd_vec;
  logic [MODE_W-1:0] mode_val;
  logic [BYTE_W-1:0] rd_bytes [NCH];
  logic [BYTE_W-1:0] rdata_d;
  logic              rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pit_cmd_decode #(.NCH(NCH)) u_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .prog_vec (prog_vec),
    .capt_vec (capt_vec),
    .dwr_vec  (dwr_vec),
    .drd_vec  (drd_vec),
    .mode_val (mode_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_chan_port u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .prog     (prog_vec[i]),
      .capt     (capt_vec[i]),
      .mode_in  (mode_val),
      .dwr      (dwr_vec[i]),
      .drd      (drd_vec[i]),
      .wdata    (wdata),
      .live     (live_count[i*CNT_W +: CNT_W]),
      .mode_q   (chan_mode[i*MODE_W +: MODE_W]),
      .mset_q   (mode_set[i]),
      .load_q   (load_pulse[i]),
      .preset_q (preset[i*CNT_W +: CNT_W]),
      .rd_byte  (rd_bytes[i])
    );
  end

  assign rd_hit = |drd_vec;

  always_comb begin
    rdata_d = rdata;
    for (int i = 0; i < NCH; i++) begin
      if (drd_vec[i]) rdata_d = rd_bytes[i];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rdata <= '0;
    else if (rd_hit)  rdata <= rdata_d;
  end
endmodule

// File: rtl/pit_host_if_chk.sv
module pit_host_if_chk
  import pit_if_pkg::*;
#(
  parameter int unsigned NCH = 3,
  localparam int unsigned AW = $clog2(NCH + 1)
) (
  input logic                  clk,
  input logic                  rst_core_n,
  input logic [AW-1:0]         addr,
  input logic                  wr_en,
  input logic [BYTE_W-1:0]     wdata,
  input logic [NCH*MODE_W-1:0] chan_mode,
  input logic [NCH-1:0]        mode_set,
  input logic [NCH-1:0]        load_pulse,
  input logic [NCH*CNT_W-1:0]  preset
);
  logic cmd_wr;
  assign cmd_wr = wr_en && (addr == AW'(NCH));

  assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(load_pulse));

  assert_reserved_sel_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd_wr && wdata[7:6] == 2'b11) |=> ($stable(chan_mode) && $stable(preset) && mode_set == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_prog_clears_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
      (cmd_wr && wdata[7:6] == 2'(c) && wdata[5:4] == 2'b11)
        |=> (preset[c*CNT_W +: CNT_W] == '0 && mode_set[c]
             && chan_mode[c*MODE_W +: MODE_W] == $past(wdata[3:1])));

    assert_mode_source_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
      !$stable(chan_mode[c*MODE_W +: MODE_W]) |-> $past(cmd_wr));

    assert_load_source_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
      load_pulse[c] |-> $past(wr_en && addr == AW'(c)));
  end
endmodule

bind pit_host_if pit_host_if_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .chan_mode  (chan_mode),
  .mode_set   (mode_set),
  .load_pulse (load_pulse),
  .preset     (preset)
);

// File: tb/pit_host_if_test.sv
module pit_host_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live_count = '0;
  logic [8:0]  chan_mode;
  logic [2:0]  mode_set;
  logic [2:0]  load_pulse;
  logic [47:0] preset;

  int n_checks = 0;
  int n_fail   = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  pit_host_if uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_count(live_count), .chan_mode(chan_mode),
    .mode_set(mode_set), .load_pulse(load_pulse), .preset(preset)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en && (addr != 2'd3);

  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen) begin
        if (exp_q.size() == 0) begin
          chk("R11 unexpected read", 48'(rdata), 48'hX);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, 48'(rdata), 48'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] pre_save;
    logic [8:0]  mode_save;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", 48'(rdata), 48'h0);
    chk("R1 chan_mode", 48'(chan_mode), 48'h0);
    chk("R1 preset", preset, 48'h0);
    chk("R1 load_pulse", 48'(load_pulse), 48'h0);
    chk("R1 mode_set", 48'(mode_set), 48'h0);

    // R2 program channel 1 to mode 2: sel 01, acc 11, mode 010
    wr(2'd3, 8'h74);
    chk("R2 mode_set pulse", 48'(mode_set), 48'h2);
    chk("R2 mode value", 48'(chan_mode[5:3]), 48'h2);
    @(negedge clk);
    chk("R2 mode_set one cycle", 48'(mode_set), 48'h0);

    // R3 two-byte reload value
    wr(2'd1, 8'h34);
    chk("R3 no load after first byte", 48'(load_pulse), 48'h0);
    wr(2'd1, 8'h12);
    chk("R3 load pulse", 48'(load_pulse), 48'h2);
    chk("R3 preset value", 48'(preset[31:16]), 48'h1234);
    @(negedge clk);
    chk("R3 load one cycle", 48'(load_pulse), 48'h0);

    // R2 mode command clears reload value
    wr(2'd3, 8'h76);
    chk("R2 preset cleared", 48'(preset[31:16]), 48'h0);
    chk("R2 new mode", 48'(chan_mode[5:3]), 48'h3);

    // R8 pending low byte discarded by mode command
    wr(2'd1, 8'hAA);
    wr(2'd3, 8'h76);
    wr(2'd1, 8'h55);
    chk("R8 no load after restart byte", 48'(load_pulse), 48'h0);
    wr(2'd1, 8'h66);
    chk("R8 preset after restart", 48'(preset[31:16]), 48'h6655);

    // R9 reserved select ignored
    pre_save = preset; mode_save = chan_mode;
    wr(2'd3, 8'hF6);
    chk("R9 mode unchanged", 48'(chan_mode), 48'(mode_save));
    chk("R9 preset unchanged", preset, pre_save);
    chk("R9 no mode_set", 48'(mode_set), 48'h0);

    // R10 single-byte access codes ignored (channel 0, acc 01 then acc 10)
    wr(2'd3, 8'h18);
    chk("R10 acc01 no mode_set", 48'(mode_set), 48'h0);
    wr(2'd3, 8'h28);
    chk("R10 acc10 mode unchanged", 48'(chan_mode), 48'(mode_save));
    chk("R10 preset unchanged", preset, pre_save);

    // R4 capture channel 2, mode kept
    live_count[47:32] = 16'hBEEF;
    wr(2'd3, 8'h80);
    chk("R4 mode unchanged", 48'(chan_mode), 48'(mode_save));
    live_count[47:32] = 16'h1111;
    rd(2'd2, 8'hEF, "R5 captured low byte");
    // R6 second capture while held is ignored
    wr(2'd3, 8'h80);
    rd(2'd2, 8'hBE, "R6 captured high byte kept");
    // R7 live reads when nothing held
    live_count[47:32] = 16'h2233;
    rd(2'd2, 8'h33, "R7 live low byte");
    rd(2'd2, 8'h22, "R7 live high byte");

    // R12 interleaved captures of channels 0 and 2
    live_count[15:0]  = 16'h0A0B;
    live_count[47:32] = 16'hCCDD;
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h80);
    live_count = '0;
    rd(2'd0, 8'h0B, "R12 ch0 low");
    rd(2'd2, 8'hDD, "R12 ch2 low");
    rd(2'd0, 8'h0A, "R12 ch0 high");
    rd(2'd2, 8'hCC, "R12 ch2 high");

    // R11 rdata holds without reads
    repeat (3) @(negedge clk);
    chk("R11 rdata held", 48'(rdata), 48'hCC);
    chk("R11 all reads consumed", 48'(exp_q.size()), 48'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule